// File: doc/BRIEF.md
# Supply Reset Supervisor With Delay

This block turns a set of per-channel undervoltage flags into one active-low system reset. While any supply that takes part in monitoring sits below its threshold, the reset is held asserted (low), with no clock edge between the flag and the output. The reset is released only once every participating supply has stayed good for an uninterrupted run of clock cycles. That run length is programmable, and a built-in floor stops it from dropping below a minimum.

A participation mask removes channels from the all-good test. A two-bit encoded override input models a pin that can be left open or driven. Driving it to either level forces the reset released, which is how supplies are margined without a reset. Returning it to open restores normal supervision. Analog comparison and the electrical behaviour of the output are outside this block: the flags arrive already digitised and synchronous to the clock.

Top module: `supv_reset_gen`

## Requirements
- R1: With the override open, the output `rst_n_out` is low in the same cycle that any channel with `ch_mask` bit 1 has its `uv_flag` bit at 1 (1 means below threshold).
- R2: With the override open, the output goes high only once all participating channels have been good for E consecutive rising clock edges, where E is the effective delay. It goes high right after the E-th such edge.
- R3: A participating channel that goes bad at any point during the delay run clears the run, and a fresh run of E good edges is needed.
- R4: A channel whose `ch_mask` bit is 0 has no effect on the output, whatever its `uv_flag` value.
- R5: The override encoding `ovr_pin` is 2'b00 for open (normal operation), 2'b01 for driven high and 2'b10 for driven low. The value 2'b11 also counts as driven. Any value other than 2'b00 forces `rst_n_out` high in the same cycle.
- R6: The effective delay E equals `dly_cfg` when `dly_cfg` is at least `MIN_DELAY`, and equals `MIN_DELAY` otherwise. This includes `dly_cfg` = 0.
- R7: The synchronous reset `rst` clears the delay run. Afterwards the output stays low until a full run of E good edges completes.
- R8: Forcing through the override does not count as good time. Once the override returns to open, the output follows the supplies and the delay run as in R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_flag | input | N_CH | Per-channel undervoltage flag, 1 = below threshold |
| ch_mask | input | N_CH | Per-channel participation, 1 = monitored |
| ovr_pin | input | 2 | Decoded state of the three-state override input |
| dly_cfg | input | CNT_W | Requested release delay in clock cycles |
| rst_n_out | output | 1 | System reset, active low |

## Verification
The assertions assume that `dly_cfg` is held steady while the delay run is in progress or the reset is released. The only exception is a change made in the same cycle that the supplies turn good. They also assume that `uv_flag`, `ch_mask` and `ovr_pin` are synchronous to `clk`. The stimulus changes every input only on the falling edge. It alters `dly_cfg` only while a participating supply is bad, or together with the step that makes all supplies good. Mask changes made while the reset is released never change the all-good result.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Encoding of the three-state override input after pin decode
    typedef enum logic [1:0] {
        OVR_OPEN  = 2'b00,
        OVR_HIGH  = 2'b01,
        OVR_LOW   = 2'b10,
        OVR_BOTH  = 2'b11
    } ovr_pin_e;

    typedef struct packed {
        logic forced;    // any driven level releases reset
        logic level_hi;  // which level is driven, for observation only
    } ovr_dec_t;

    function automatic logic ovr_forced(input logic [1:0] pin);
        return pin != OVR_OPEN;
    endfunction

endpackage

// File: rtl/supv_ovr_decode.sv
module supv_ovr_decode
    import supv_pkg::*;
(
    input  logic [1:0] ovr_pin,
    output ovr_dec_t   ovr_dec
);
    always_comb begin
        ovr_dec.forced   = ovr_forced(ovr_pin);
        ovr_dec.level_hi = (ovr_pin == OVR_HIGH) || (ovr_pin == OVR_BOTH);
    end
endmodule

// File: rtl/supv_good_gate.sv
module supv_good_gate #(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] uv_flag,
    input  logic [N_CH-1:0] ch_mask,
    output logic            all_good
);
    logic [N_CH-1:0] ch_ok;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        // a channel is acceptable when it is not monitored or not low
        assign ch_ok[g] = !ch_mask[g] || !uv_flag[g];
    end

    assign all_good = &ch_ok;
endmodule

// File: rtl/supv_delay_timer.sv
module supv_delay_timer #(
    parameter int CNT_W     = 12,
    parameter int MIN_DELAY = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             good,
    input  logic [CNT_W-1:0] dly_cfg,
    output logic             done
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DELAY);

    logic [CNT_W-1:0] eff_dly;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             done_q;

    assign eff_dly = (dly_cfg < MIN_V) ? MIN_V : dly_cfg;
    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !good) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_inc;
            if (cnt_inc == eff_dly) begin
                done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int CNT_W     = 12,
    parameter int MIN_DELAY = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  uv_flag,
    input  logic [N_CH-1:0]  ch_mask,
    input  logic [1:0]       ovr_pin,
    input  logic [CNT_W-1:0] dly_cfg,
    output logic             rst_n_out
);
    ovr_dec_t ovr_dec;
    logic     all_good;
    logic     run_done;

    supv_ovr_decode u_ovr (
        .ovr_pin (ovr_pin),
        .ovr_dec (ovr_dec)
    );

    supv_good_gate #(.N_CH(N_CH)) u_gate (
        .uv_flag  (uv_flag),
        .ch_mask  (ch_mask),
        .all_good (all_good)
    );

    supv_delay_timer #(.CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .good    (all_good),
        .dly_cfg (dly_cfg),
        .done    (run_done)
    );

    // the timer's done flag lags a failure by one edge, so gate it with
    // the live all-good term to drop reset in the same cycle
    assign rst_n_out = ovr_dec.forced || (run_done && all_good);
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int N_CH      = 4,
    parameter int CNT_W     = 12,
    parameter int MIN_DELAY = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [N_CH-1:0]  uv_flag,
    input logic [N_CH-1:0]  ch_mask,
    input logic [1:0]       ovr_pin,
    input logic [CNT_W-1:0] dly_cfg,
    input logic             rst_n_out
);
    localparam int RUN_W = CNT_W + 1;

    logic             bad_any;
    logic             is_open;
    logic [RUN_W-1:0] good_run;
    logic [RUN_W-1:0] eff_chk;

    assign bad_any = |(uv_flag & ch_mask);
    assign is_open = (ovr_pin == 2'b00);
    assign eff_chk = (int'(dly_cfg) < MIN_DELAY) ? RUN_W'(MIN_DELAY)
                                                  : RUN_W'(dly_cfg);

    // independent count of consecutive good edges, saturating
    always_ff @(posedge clk) begin
        if (rst || bad_any) begin
            good_run <= '0;
        end else if (good_run != {RUN_W{1'b1}}) begin
            good_run <= good_run + 1'b1;
        end
    end

    assert_low_on_bad_R1: assert property (@(posedge clk) disable iff (rst)
        (is_open && bad_any) |-> !rst_n_out);

    assert_forced_high_R5: assert property (@(posedge clk) disable iff (rst)
        !is_open |-> rst_n_out);

    // R2, R3, R6, R7: release only after a full run of good edges
    assert_full_run_R2: assert property (@(posedge clk) disable iff (rst)
        (is_open && rst_n_out) |-> (good_run >= eff_chk));

    assert_no_release_in_bad_R8: assert property (@(posedge clk) disable iff (rst)
        (is_open && $past(is_open) && $rose(rst_n_out)) |-> !$past(bad_any));
endmodule

bind supv_reset_gen supv_reset_chk #(
    .N_CH(N_CH), .CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .uv_flag   (uv_flag),
    .ch_mask   (ch_mask),
    .ovr_pin   (ovr_pin),
    .dly_cfg   (dly_cfg),
    .rst_n_out (rst_n_out)
);

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;
    localparam int PERIOD    = 10;
    localparam int N_CH      = 4;
    localparam int CNT_W     = 12;
    localparam int MIN_DELAY = 8;
    localparam int NVEC      = 17;

    logic             clk = 1'b0;
    logic             rst;
    logic [N_CH-1:0]  uv_flag;
    logic [N_CH-1:0]  ch_mask;
    logic [1:0]       ovr_pin;
    logic [CNT_W-1:0] dly_cfg;
    logic             rst_n_out;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    supv_reset_gen #(.N_CH(N_CH), .CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)) u0 (
        .clk(clk), .rst(rst), .uv_flag(uv_flag), .ch_mask(ch_mask),
        .ovr_pin(ovr_pin), .dly_cfg(dly_cfg), .rst_n_out(rst_n_out)
    );

    // fields: uv[4] mask[4] ovr[2] dly[12] edges[8] expected[1]
    localparam logic [30:0] VEC [NVEC] = '{
        {4'b0000, 4'hF, 2'b00, 12'd10, 8'd9, 1'b0}, // R2 one edge short
        {4'b0000, 4'hF, 2'b00, 12'd10, 8'd1, 1'b1}, // R2 full run
        {4'b0001, 4'hF, 2'b00, 12'd10, 8'd0, 1'b0}, // R1 same cycle
        {4'b0000, 4'hF, 2'b00, 12'd10, 8'd5, 1'b0}, // R3 partial run
        {4'b0010, 4'hF, 2'b00, 12'd10, 8'd1, 1'b0}, // R3 glitch
        {4'b0000, 4'hF, 2'b00, 12'd10, 8'd9, 1'b0}, // R3 restarted
        {4'b0000, 4'hF, 2'b00, 12'd10, 8'd1, 1'b1}, // R3 fresh run done
        {4'b0001, 4'hE, 2'b00, 12'd10, 8'd3, 1'b1}, // R4 masked bad
        {4'b0011, 4'hE, 2'b00, 12'd10, 8'd0, 1'b0}, // R1 monitored bad
        {4'b0011, 4'hE, 2'b01, 12'd10, 8'd0, 1'b1}, // R5 driven high
        {4'b0011, 4'hE, 2'b10, 12'd10, 8'd2, 1'b1}, // R5 driven low
        {4'b0011, 4'hE, 2'b00, 12'd10, 8'd0, 1'b0}, // R8 back to open
        {4'b0000, 4'hF, 2'b00, 12'd0,  8'd7, 1'b0}, // R6 zero -> min
        {4'b0000, 4'hF, 2'b00, 12'd0,  8'd1, 1'b1}, // R6 min reached
        {4'b1000, 4'hF, 2'b00, 12'd3,  8'd2, 1'b0}, // R1 top channel
        {4'b0000, 4'hF, 2'b00, 12'd3,  8'd7, 1'b0}, // R6 below min
        {4'b0000, 4'hF, 2'b00, 12'd3,  8'd1, 1'b1}  // R6 min reached
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rst_n_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // apply at the falling edge, clock n rising edges, sample just after
    task automatic step(input logic [3:0] uv, input logic [3:0] m,
                        input logic [1:0] o, input logic [11:0] d, input int n);
        @(negedge clk);
        uv_flag = uv; ch_mask = m; ovr_pin = o; dly_cfg = d;
        #1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; uv_flag = '0; ch_mask = '1; ovr_pin = 2'b00; dly_cfg = 12'd10;
        step(4'b0000, 4'hF, 2'b00, 12'd10, 3);
        check("R7 reset state", rst_n_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        step(4'b0001, 4'hF, 2'b00, 12'd10, 1);

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][30:27], VEC[k][26:23], VEC[k][22:21], VEC[k][20:9],
                 int'(VEC[k][8:1]));
            check($sformatf("vector %0d", k), rst_n_out, VEC[k][0]);
        end

        // R7: reset while released, then a full run is needed again
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R7 mid reset", rst_n_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        step(4'b0000, 4'hF, 2'b00, 12'd3, 6);
        check("R7 after reset short", rst_n_out, 1'b0);
        step(4'b0000, 4'hF, 2'b00, 12'd3, 1);
        check("R7 after reset full", rst_n_out, 1'b1);

        // R5: 2'b11 also counts as driven
        step(4'b0100, 4'hF, 2'b11, 12'd40, 1);
        check("R5 both levels", rst_n_out, 1'b1);

        // R2: longer delay above the floor
        step(4'b0000, 4'hF, 2'b00, 12'd40, 39);
        check("R2 long delay short", rst_n_out, 1'b0);
        step(4'b0000, 4'hF, 2'b00, 12'd40, 1);
        check("R2 long delay full", rst_n_out, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule